// File: doc/BRIEF.md
# Register Rename Map Table

This block keeps, for every architectural register, a note of where its newest value lives. An entry that is ready means the architectural register file holds the current value. An entry that is pending holds the tag of the reorder-buffer slot that will produce the value. Because the lookup goes through this table, the reorder buffer never has to be searched by register number.

Each cycle the block takes one destination allocation, one commit and one flush request. It also answers a configurable number of source lookups. Allocation points the destination register at the new tag, and the newest writer always wins. A commit returns an entry to ready only if the entry still names the committing tag. If a younger writer has claimed the register since, the commit leaves the entry alone. A flush returns every entry to ready. Lookups see the table as it stood before the current cycle's updates. This lets an instruction that both reads and writes a register obtain the older producer.

Top module: `rename_map_table`

## Requirements
- R1: After reset every register reads as ready: `src_pending` is 0 and `src_tag` is 0 for every register on every port.
- R2: An allocation to register r (r not 0) without flush makes r read pending with the allocated tag from the next cycle on.
- R3: A lookup in the same cycle as an allocation to the same register returns the state from before that allocation.
- R4: A newer allocation to a register replaces an older mapping, so the lookup returns the newest tag.
- R5: A commit whose tag equals the tag stored for a pending register makes that register ready in the next cycle.
- R6: A commit whose tag differs from the stored tag leaves the register pending with its stored tag unchanged.
- R7: A flush makes every register ready in the next cycle and takes priority over an allocation in the same cycle.
- R8: Register 0 always reads ready; allocations to register 0 are ignored.
- R9: When an allocation and a matching commit hit the same register in one cycle, the allocation wins and the register reads pending with the new tag.
- R10: Each lookup port independently reports the state of the register on its own select lines.
- R11: A ready register reads with `src_tag` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_en | input | 1 | Destination allocation request |
| alloc_reg | input | REG_W | Destination register number |
| alloc_tag | input | TAG_W | Reorder-buffer tag assigned to the destination |
| commit_en | input | 1 | Commit request |
| commit_reg | input | REG_W | Register written by the committing instruction |
| commit_tag | input | TAG_W | Tag of the committing instruction |
| flush | input | 1 | Clear every mapping |
| src_reg | input | NUM_SRC*REG_W | Source register selects, port i at bits [i*REG_W +: REG_W] |
| src_pending | output | NUM_SRC | 1 when the looked-up register waits on a tag |
| src_tag | output | NUM_SRC*TAG_W | Producer tag per port, 0 when ready |

## Verification
The hardest case to reach is a stale commit: the register must have been allocated twice before the older writer commits. Only then does a tag mismatch have anything to protect. The stimulus remaps each register before it commits the older tag. It then sweeps every pair of mapped tag and committing tag on one register, so that every match and mismatch is covered. The case where allocation and commit hit the same register in one cycle is also driven on purpose.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

    // Per-entry update selected each cycle
    typedef enum logic [1:0] {
        UPD_KEEP = 2'd0,
        UPD_MAP  = 2'd1,
        UPD_FREE = 2'd2
    } rmt_upd_e;

endpackage

// File: rtl/rmt_entry_ctl.sv
module rmt_entry_ctl
    import rmt_pkg::*;
#(
    parameter int IDX   = 1,
    parameter int REG_W = 5,
    parameter int TAG_W = 5
) (
    input  logic             flush,
    input  logic             alloc_en,
    input  logic [REG_W-1:0] alloc_reg,
    input  logic             commit_en,
    input  logic [REG_W-1:0] commit_reg,
    input  logic [TAG_W-1:0] commit_tag,
    input  logic             cur_pend,
    input  logic [TAG_W-1:0] cur_tag,
    output rmt_upd_e         upd
);

    localparam logic [REG_W-1:0] MY_REG = REG_W'(IDX);

    logic alloc_hit;
    logic commit_hit;

    always_comb begin
        alloc_hit  = alloc_en && (alloc_reg == MY_REG);
        commit_hit = commit_en && (commit_reg == MY_REG) && cur_pend && (cur_tag == commit_tag);
        if (flush) begin
            upd = UPD_FREE;
        end else if (alloc_hit) begin
            upd = UPD_MAP;
        end else if (commit_hit) begin
            upd = UPD_FREE;
        end else begin
            upd = UPD_KEEP;
        end
    end

endmodule

// File: rtl/rmt_read_port.sv
module rmt_read_port #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 5,
    parameter int TAG_W    = 5
) (
    input  logic [NUM_REGS-1:0]       pend,
    input  logic [NUM_REGS*TAG_W-1:0] tags,
    input  logic [REG_W-1:0]          sel,
    output logic                      pending,
    output logic [TAG_W-1:0]          tag
);

    always_comb begin
        pending = pend[sel] && (sel != '0);
        tag     = pending ? tags[sel*TAG_W +: TAG_W] : '0;
    end

endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
    import rmt_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 5,
    parameter int NUM_SRC  = 2,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_en,
    input  logic [REG_W-1:0]         alloc_reg,
    input  logic [TAG_W-1:0]         alloc_tag,
    input  logic                     commit_en,
    input  logic [REG_W-1:0]         commit_reg,
    input  logic [TAG_W-1:0]         commit_tag,
    input  logic                     flush,
    input  logic [NUM_SRC*REG_W-1:0] src_reg,
    output logic [NUM_SRC-1:0]       src_pending,
    output logic [NUM_SRC*TAG_W-1:0] src_tag
);

    typedef struct packed {
        logic [NUM_REGS-1:0]            pend;
        logic [NUM_REGS-1:0][TAG_W-1:0] tag;
    } state_t;

    state_t   state_d, state_q;
    rmt_upd_e upd [NUM_REGS];

    // Per-register update decision; register 0 is fixed
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        if (g == 0) begin : g_zero
            assign upd[g] = UPD_KEEP;
        end else begin : g_live
            rmt_entry_ctl #(
                .IDX   (g),
                .REG_W (REG_W),
                .TAG_W (TAG_W)
            ) u_ctl (
                .flush      (flush),
                .alloc_en   (alloc_en),
                .alloc_reg  (alloc_reg),
                .commit_en  (commit_en),
                .commit_reg (commit_reg),
                .commit_tag (commit_tag),
                .cur_pend   (state_q.pend[g]),
                .cur_tag    (state_q.tag[g]),
                .upd        (upd[g])
            );
        end
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            case (upd[i])
                UPD_MAP: begin
                    state_d.pend[i] = 1'b1;
                    state_d.tag[i]  = alloc_tag;
                end
                UPD_FREE: begin
                    state_d.pend[i] = 1'b0;
                    state_d.tag[i]  = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Lookups read the registered state, before this cycle's updates
    for (genvar p = 0; p < NUM_SRC; p++) begin : g_src
        rmt_read_port #(
            .NUM_REGS (NUM_REGS),
            .REG_W    (REG_W),
            .TAG_W    (TAG_W)
        ) u_rd (
            .pend    (state_q.pend),
            .tags    (state_q.tag),
            .sel     (src_reg[p*REG_W +: REG_W]),
            .pending (src_pending[p]),
            .tag     (src_tag[p*TAG_W +: TAG_W])
        );
    end

    a_r2_alloc_maps: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && !flush && alloc_reg != '0)
        |=> (state_q.pend[$past(alloc_reg)] && state_q.tag[$past(alloc_reg)] == $past(alloc_tag)));

    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q.pend == '0));

    a_r8_zero_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.pend[0]);

    a_r5_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && !flush && state_q.pend[commit_reg] && state_q.tag[commit_reg] == commit_tag
         && !(alloc_en && alloc_reg == commit_reg))
        |=> !state_q.pend[$past(commit_reg)]);

    a_r6_stale_commit_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && !flush && state_q.pend[commit_reg] && state_q.tag[commit_reg] != commit_tag
         && !(alloc_en && alloc_reg == commit_reg))
        |=> (state_q.pend[$past(commit_reg)] && state_q.tag[$past(commit_reg)] == $past(state_q.tag[commit_reg])));

endmodule

// File: tb/rename_map_table_bench.sv
module rename_map_table_bench;

    localparam int NR = 8;
    localparam int TW = 3;
    localparam int NS = 2;
    localparam int RW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            alloc_en = 1'b0;
    logic [RW-1:0]   alloc_reg = '0;
    logic [TW-1:0]   alloc_tag = '0;
    logic            commit_en = 1'b0;
    logic [RW-1:0]   commit_reg = '0;
    logic [TW-1:0]   commit_tag = '0;
    logic            flush = 1'b0;
    logic [NS*RW-1:0] src_reg = '0;
    logic [NS-1:0]    src_pending;
    logic [NS*TW-1:0] src_tag;

    int errors = 0;
    int checks = 0;
    int mp [NR];
    int mt [NR];

    always #10 clk = ~clk;

    rename_map_table #(.NUM_REGS(NR), .TAG_W(TW), .NUM_SRC(NS)) u_rename_map_table (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_reg(alloc_reg), .alloc_tag(alloc_tag),
        .commit_en(commit_en), .commit_reg(commit_reg), .commit_tag(commit_tag),
        .flush(flush), .src_reg(src_reg),
        .src_pending(src_pending), .src_tag(src_tag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    // Compare every register against the model, port 0 on r and port 1 on NR-1-r (R10)
    task automatic check_all(input string req);
        for (int r = 0; r < NR; r++) begin
            src_reg = {RW'(NR-1-r), RW'(r)};
            #1;
            chk(req, int'(src_pending[0]), mp[r]);
            chk(req, int'(src_tag[TW-1:0]), mp[r] ? mt[r] : 0);
            chk({req, "/R10"}, int'(src_pending[1]), mp[NR-1-r]);
            chk({req, "/R11"}, int'(src_tag[2*TW-1:TW]), mp[NR-1-r] ? mt[NR-1-r] : 0);
        end
    endtask

    // Drive one cycle, with model update derived from the requirements
    task automatic cycle(input bit a, input int ar, input int at,
                         input bit c, input int cr, input int ct, input bit f);
        alloc_en = a; alloc_reg = RW'(ar); alloc_tag = TW'(at);
        commit_en = c; commit_reg = RW'(cr); commit_tag = TW'(ct);
        flush = f;
        tick();
        if (f) begin
            for (int r = 0; r < NR; r++) begin mp[r] = 0; mt[r] = 0; end
        end else begin
            if (c && mp[cr] == 1 && mt[cr] == ct && !(a && ar == cr)) begin
                mp[cr] = 0; mt[cr] = 0;
            end
            if (a && ar != 0) begin
                mp[ar] = 1; mt[ar] = at;
            end
        end
        alloc_en = 1'b0; commit_en = 1'b0; flush = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++) begin mp[r] = 0; mt[r] = 0; end
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check_all("R1");

        // R2 with R3: same-cycle lookup sees the prior state
        for (int r = 1; r < NR; r++) begin
            alloc_en = 1'b1; alloc_reg = RW'(r); alloc_tag = TW'((r + 3) % NR);
            src_reg = {RW'(r), RW'(r)};
            #1;
            chk("R3", int'(src_pending[0]), 0);
            cycle(1, r, (r + 3) % NR, 0, 0, 0, 0);
        end
        check_all("R2");

        // R8: allocation to register 0 ignored
        cycle(1, 0, 5, 0, 0, 0, 0);
        src_reg = '0; #1;
        chk("R8", int'(src_pending[0]), 0);
        chk("R8", int'(src_tag[TW-1:0]), 0);

        // R4 with R3 on an already-mapped register
        for (int r = 1; r < NR; r++) begin
            alloc_en = 1'b1; alloc_reg = RW'(r); alloc_tag = TW'((r + 6) % NR);
            src_reg = {RW'(r), RW'(r)};
            #1;
            chk("R3", int'(src_tag[TW-1:0]), (r + 3) % NR);
            cycle(1, r, (r + 6) % NR, 0, 0, 0, 0);
        end
        check_all("R4");

        // R6: older writer commits, younger mapping survives
        for (int r = 1; r < NR; r++) cycle(0, 0, 0, 1, r, (r + 3) % NR, 0);
        check_all("R6");

        // R5: current writer commits
        for (int r = 1; r < NR; r += 2) cycle(0, 0, 0, 1, r, (r + 6) % NR, 0);
        check_all("R5");

        // R9: allocate and matching commit on one register in one cycle
        cycle(1, 3, 2, 0, 0, 0, 0);
        cycle(1, 3, 7, 1, 3, 2, 0);
        src_reg = {RW'(0), RW'(3)}; #1;
        chk("R9", int'(src_pending[0]), 1);
        chk("R9", int'(src_tag[TW-1:0]), 7);

        // R7: flush beats a same-cycle allocation
        for (int r = 1; r < NR; r++) cycle(1, r, r, 0, 0, 0, 0);
        cycle(1, 4, 1, 0, 0, 0, 1);
        check_all("R7");

        // R5/R6 sweep: every mapped tag against every committing tag
        for (int m = 0; m < NR; m++) begin
            for (int c = 0; c < NR; c++) begin
                cycle(1, 2, m, 0, 0, 0, 0);
                cycle(0, 0, 0, 1, 2, c, 0);
                src_reg = {RW'(5), RW'(2)}; #1;
                chk(c == m ? "R5" : "R6", int'(src_pending[0]), (c == m) ? 0 : 1);
                chk("R11", int'(src_tag[TW-1:0]), (c == m) ? 0 : m);
            end
        end
        check_all("R6");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule